// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a four-bit record of what put the chip into reset most recently. It watches four synchronous indications: a power-on request, the external reset pin, the watchdog timeout line (qualified by a watchdog-reset-enable bit) and a supply-below-brown-out-threshold level. Boot software reads the record to tell a cold start from a warm one, then clears the flags it has handled by writing ones to them.

The register is reset only by the power-on request. The external, watchdog and brown-out resets leave it intact, so its contents survive those resets. Each non-power-on source changes the record in the clock cycle in which it deasserts. A source that is still held when the power-on request ends is therefore recorded when it later lets go.

A small sequencer follows the reset condition of the chip and has three states. ST_COLD is the state while the power-on request is high. ST_HELD is the state while any non-power-on reset source is held. ST_RUN is the state when no source is active. The transitions are as follows:
- ST_COLD goes to ST_HELD or to ST_RUN when the power-on request drops.
- ST_RUN goes to ST_HELD when a source asserts.
- ST_HELD goes to ST_RUN when all sources are released.
- Any state goes to ST_COLD on a power-on request.

Software writes are taken only when the sequencer state registered at that clock edge is ST_RUN.

Top module: `rcause_reg`

## Requirements
- R1: The read port shows the power-on flag in bit 0, the external-pin flag in bit 1, the watchdog flag in bit 2 and the brown-out flag in bit 3. Bits 31 to 4 always read as zero.
- R2: A write accepted in ST_RUN clears every flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged, and so do write-data bits 31 to 4. A flag set by a source event at the same edge stays set.
- R3: While the power-on request is high, the record becomes 0x1 at each clock edge, and writes are ignored.
- R4: If a non-power-on source is still held when the power-on request falls, its flag is set at the edge where that source deasserts.
- R5: The power-on flag is set only by the power-on request. The external, watchdog and brown-out events never change it.
- R6: The external flag is set at the edge where the external reset pin deasserts. Only a power-on request or a write clears it. Watchdog and brown-out events do not affect it.
- R7: The watchdog flag is set when the timeout line falls, provided the enable bit was 1 in the last cycle of the timeout. A timeout with the enable at 0 has no effect. An external or brown-out release clears the watchdog flag, and this clear wins over a watchdog event at the same edge.
- R8: The brown-out flag is set at the edge where the supply-low level deasserts, which includes the first rise after power-on. Watchdog and external events do not affect it. A dip that turns into a power-on request clears it through R3.
- R9: The sequencer moves between ST_COLD, ST_HELD and ST_RUN as the brief describes. A write that arrives while the registered state is ST_COLD or ST_HELD has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_req | input | 1 | Power-on reset request, active high |
| ext_rst_req | input | 1 | External reset pin request, active high |
| wdt_timeout | input | 1 | Watchdog timeout level from the counter |
| wdt_rst_en | input | 1 | Watchdog timeout is allowed to reset the chip |
| bod_low | input | 1 | Supply is below the brown-out threshold |
| wr_en | input | 1 | Write strobe for the clear-by-one port |
| wr_data | input | 32 | Write data; a 1 in bits 3..0 clears that flag |
| rd_data | output | 32 | Flags in bits 3..0, zero above |

## Verification
The assertions assume the following about the inputs:
- Every input is synchronous to clk.
- The power-on request is high at the first clock edge, so that the record and the release-detection registers hold defined values before any property is evaluated.
- Properties are disabled while the power-on request is high, because the record is rebuilt from scratch in that period.

The stimulus always opens with several power-on cycles and changes the inputs only on falling clock edges. Random activity draws new power-on requests rarely and holds them for a few cycles. Beyond these constraints, each source is allowed to assert and release in any combination, including releases in the same cycle.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int FLAG_W  = 4;
    localparam int BIT_POR = 0;
    localparam int BIT_EXT = 1;
    localparam int BIT_WDT = 2;
    localparam int BIT_BOD = 3;

    // non-power-on sources, in release-detector order
    localparam int SRC_N   = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_WDT = 1;
    localparam int SRC_BOD = 2;

    typedef enum logic [1:0] {
        ST_COLD = 2'd0,
        ST_HELD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/rcause_release.sv
// Flags the cycle in which a source drops, qualified by a per-source
// enable that was valid in the last cycle the source was high.
module rcause_release #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic [N-1:0] src,
    input  logic [N-1:0] qual,
    output logic [N-1:0] released
);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic src_q;
        logic qual_q;

        always_ff @(posedge clk) begin
            src_q  <= src[i];
            qual_q <= qual[i];
        end

        assign released[i] = src_q & qual_q & ~src[i];
    end

endmodule

// File: rtl/rcause_seq.sv
// Chip reset-phase sequencer: decides when software writes are accepted.
module rcause_seq
    import rcause_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       held,
    output seq_state_t state,
    output logic       wr_ok
);

    seq_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (por) state <= ST_COLD;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COLD: state_nxt = held ? ST_HELD : ST_RUN;
            ST_HELD: if (!held) state_nxt = ST_RUN;
            ST_RUN:  if (held)  state_nxt = ST_HELD;
            default: state_nxt = ST_COLD;
        endcase
    end

    always_comb begin
        wr_ok = 1'b0;
        unique case (state)
            ST_COLD: wr_ok = 1'b0;
            ST_HELD: wr_ok = 1'b0;
            ST_RUN:  wr_ok = 1'b1;
            default: wr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/rcause_flags.sv
// The cause record. Only power-on reinitialises it.
module rcause_flags
    import rcause_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic             clk,
    input  logic             por,
    input  logic             wr_ok,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_mask,
    input  logic [SRC_N-1:0] released,
    output logic [W-1:0]     flags
);

    localparam logic [W-1:0] COLD_VAL = W'(1) << BIT_POR;

    logic [W-1:0] flags_nxt;

    always_comb begin
        flags_nxt = flags;
        if (wr_ok && wr_en)
            flags_nxt = flags_nxt & ~wr_mask;
        if (released[SRC_EXT]) flags_nxt[BIT_EXT] = 1'b1;
        if (released[SRC_BOD]) flags_nxt[BIT_BOD] = 1'b1;
        if (released[SRC_WDT]) flags_nxt[BIT_WDT] = 1'b1;
        // any other source wipes the watchdog cause, even in the same cycle
        if (released[SRC_EXT] || released[SRC_BOD])
            flags_nxt[BIT_WDT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (por) flags <= COLD_VAL;
        else     flags <= flags_nxt;
    end

endmodule

// File: rtl/rcause_reg.sv
module rcause_reg
    import rcause_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_req,
    input  logic              ext_rst_req,
    input  logic              wdt_timeout,
    input  logic              wdt_rst_en,
    input  logic              bod_low,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - FLAG_W;

    logic [SRC_N-1:0]  src_vec;
    logic [SRC_N-1:0]  qual_vec;
    logic [SRC_N-1:0]  released;
    logic [FLAG_W-1:0] flags;
    logic              held;
    logic              wr_ok;
    seq_state_t        seq_q;
    logic              unused_hi;

    always_comb begin
        src_vec           = '0;
        qual_vec          = '1;
        src_vec[SRC_EXT]  = ext_rst_req;
        src_vec[SRC_WDT]  = wdt_timeout;
        src_vec[SRC_BOD]  = bod_low;
        qual_vec[SRC_WDT] = wdt_rst_en;
    end

    assign held      = |(src_vec & qual_vec);
    assign unused_hi = ^wr_data[DATA_W-1:FLAG_W];

    rcause_release #(.N(SRC_N)) u_rel (
        .clk      (clk),
        .src      (src_vec),
        .qual     (qual_vec),
        .released (released)
    );

    rcause_seq u_seq (
        .clk   (clk),
        .por   (por_req),
        .held  (held),
        .state (seq_q),
        .wr_ok (wr_ok)
    );

    rcause_flags #(.W(FLAG_W)) u_flags (
        .clk      (clk),
        .por      (por_req),
        .wr_ok    (wr_ok),
        .wr_en    (wr_en),
        .wr_mask  (wr_data[FLAG_W-1:0]),
        .released (released),
        .flags    (flags)
    );

    assign rd_data = {{PAD_W{1'b0}}, flags};

endmodule

// File: rtl/rcause_chk.sv
module rcause_chk
    import rcause_pkg::*;
(
    input logic        clk,
    input logic        por_req,
    input logic        wdt_timeout,
    input logic        wdt_rst_en,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input seq_state_t  seq_state
);

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (por_req)
        rd_data[31:4] == 28'h0);

    a_r2_por_bit_clear: assert property (@(posedge clk) disable iff (por_req)
        (wr_en && wr_data[0] && seq_state == ST_RUN) |=> !rd_data[0]);

    a_r3_cold_value: assert property (@(posedge clk) disable iff (por_req)
        $fell(por_req) |-> rd_data[3:0] == 4'b0001);

    a_r5_por_bit_source: assert property (@(posedge clk) disable iff (por_req)
        $rose(rd_data[0]) |-> $past(por_req));

    a_r6_ext_kept: assert property (@(posedge clk) disable iff (por_req)
        (rd_data[1] && !(wr_en && wr_data[1] && seq_state == ST_RUN)) |=> rd_data[1]);

    a_r7_wdt_needs_enable: assert property (@(posedge clk) disable iff (por_req)
        $rose(rd_data[2]) |-> ($past(wdt_timeout, 2) && $past(wdt_rst_en, 2) && !$past(wdt_timeout)));

    a_r8_bod_kept: assert property (@(posedge clk) disable iff (por_req)
        (rd_data[3] && !(wr_en && wr_data[3] && seq_state == ST_RUN)) |=> rd_data[3]);

    a_r9_write_gated: assert property (@(posedge clk) disable iff (por_req)
        (wr_en && wr_data[1] && seq_state != ST_RUN && rd_data[1]) |=> rd_data[1]);

endmodule

bind rcause_reg rcause_chk chk_i (
    .clk         (clk),
    .por_req     (por_req),
    .wdt_timeout (wdt_timeout),
    .wdt_rst_en  (wdt_rst_en),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .seq_state   (seq_q)
);

// File: tb/rcause_reg_test.sv
`timescale 1ns/1ps
module rcause_reg_test;

    logic        clk = 1'b0;
    logic        por_req = 1'b1;
    logic        ext_rst_req = 1'b0;
    logic        wdt_timeout = 1'b0;
    logic        wdt_rst_en = 1'b0;
    logic        bod_low = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;

    int n_cmp  = 0;
    int n_fail = 0;

    // reference state
    logic [3:0] m_flags = 4'h1;
    logic       p_ext = 1'b0, p_wdt = 1'b0, p_en = 1'b0, p_bod = 1'b0;
    int         m_state = 0;   // 0 cold, 1 held, 2 run

    always #5 clk = ~clk;

    rcause_reg uut (
        .clk         (clk),
        .por_req     (por_req),
        .ext_rst_req (ext_rst_req),
        .wdt_timeout (wdt_timeout),
        .wdt_rst_en  (wdt_rst_en),
        .bod_low     (bod_low),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data)
    );

    function automatic logic [3:0] ref_next(
        input logic [3:0] f, input logic p, input logic e, input logic w,
        input logic b, input logic we, input logic [3:0] wm, input int st);
        logic [3:0] n;
        logic rel_e, rel_w, rel_b;
        if (p) return 4'b0001;
        n = f;
        if (we && st == 2) n = n & ~wm;
        rel_e = p_ext & ~e;
        rel_w = p_wdt & p_en & ~w;
        rel_b = p_bod & ~b;
        if (rel_e) n[1] = 1'b1;
        if (rel_b) n[3] = 1'b1;
        if (rel_w) n[2] = 1'b1;
        if (rel_e || rel_b) n[2] = 1'b0;
        return n;
    endfunction

    task automatic tick(input logic p, input logic e, input logic w, input logic en,
                        input logic b, input logic we, input logic [3:0] wm);
        logic [31:0] r;
        r = $urandom();
        @(negedge clk);
        por_req = p; ext_rst_req = e; wdt_timeout = w; wdt_rst_en = en;
        bod_low = b; wr_en = we; wr_data = {r[31:4], wm};
        @(posedge clk);
        #1;
        m_flags = ref_next(m_flags, p, e, w, b, we, wm, m_state);
        if (p) m_state = 0;
        else if (e || b || (w && en)) m_state = 1;
        else m_state = 2;
        p_ext = e; p_wdt = w; p_en = en; p_bod = b;
    endtask

    task automatic chk(input string tag);
        n_cmp++;
        if (rd_data !== {28'h0, m_flags}) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, {28'h0, m_flags});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        logic e, w, en, b, p;
        void'($urandom(32'd4711));

        // R3: cold start, write ignored while held in power-on
        tick(1, 0, 0, 0, 0, 0, 4'h0);
        tick(1, 0, 0, 0, 0, 1, 4'hF);
        chk("R3 cold value");
        chk("R1 upper bits zero");
        idle(2);
        chk("R3 after release");

        // R2: zero write no effect, one clears
        tick(0, 0, 0, 0, 0, 1, 4'h0);
        chk("R2 zero write");
        tick(0, 0, 0, 0, 0, 1, 4'h1);
        chk("R2 clear power-on bit");

        // R6: external pulse
        tick(0, 1, 0, 0, 0, 0, 4'h0);
        tick(0, 1, 0, 0, 0, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 4'h0);
        chk("R6 external set on release");

        // R9: write during held ignored
        tick(0, 1, 0, 0, 0, 0, 4'h0);
        tick(0, 1, 0, 0, 0, 1, 4'h2);
        chk("R9 write in held ignored");
        tick(0, 0, 0, 0, 0, 0, 4'h0);
        idle(1);

        // R7: timeout without enable, then with enable
        tick(0, 0, 1, 0, 0, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 4'h0);
        chk("R7 timeout without enable");
        tick(0, 0, 1, 1, 0, 0, 4'h0);
        tick(0, 0, 1, 1, 0, 0, 4'h0);
        tick(0, 0, 0, 1, 0, 0, 4'h0);
        chk("R7 enabled timeout sets");
        chk("R6 external kept over watchdog");

        // R8: brown-out dip clears watchdog, keeps external
        tick(0, 0, 0, 0, 1, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 4'h0);
        chk("R8 dip sets brown-out");
        chk("R7 cleared by brown-out");

        // R7: simultaneous external and watchdog release
        tick(0, 1, 1, 1, 0, 0, 4'h0);
        tick(0, 0, 0, 1, 0, 0, 4'h0);
        chk("R7 clear wins at same edge");
        idle(1);
        tick(0, 0, 0, 0, 0, 1, 4'hF);
        chk("R2 clear all");

        // R4 / R5: power-on with external still held afterwards
        tick(1, 1, 0, 0, 0, 0, 4'h0);
        tick(1, 1, 0, 0, 0, 0, 4'h0);
        tick(0, 1, 0, 0, 0, 0, 4'h0);
        tick(0, 1, 0, 0, 0, 0, 4'h0);
        chk("R5 power-on bit kept while external held");
        tick(0, 0, 0, 0, 0, 0, 4'h0);
        chk("R4 external recorded after power-on");

        // R8: dip into power-on, slow recovery
        tick(0, 0, 0, 0, 1, 0, 4'h0);
        tick(1, 0, 0, 0, 1, 0, 4'h0);
        chk("R8 power-on clears during dip");
        tick(0, 0, 0, 0, 1, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 4'h0);
        chk("R8 recovery after power-on sets");

        // random phase
        e = 0; w = 0; en = 0; b = 0; p = 0;
        for (int i = 0; i < 6000; i++) begin
            if (($urandom() % 8) == 0) e = ~e;
            if (($urandom() % 6) == 0) w = ~w;
            if (($urandom() % 4) == 0) en = ~en;
            if (($urandom() % 10) == 0) b = ~b;
            if (p) p = (($urandom() % 3) != 0);
            else   p = (($urandom() % 250) == 0);
            tick(p, e, w, en, b, (($urandom() % 3) == 0), 4'($urandom()));
            chk("R9 random sequence");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule